// File: doc/BRIEF.md
# Edge-Capture Timer

This block is a free-running up-counter with two capture registers. A small register bus sets it up and reads it back. Each count step is taken from one of four tick sources. The first source is rising edges on an external pin. The other three are pre-divided tick pulses produced elsewhere in the chip.

A compare register holds a match value. Optionally, reaching that value sends the counter back to zero. Each time the match is reached, a match output flips its level.

Hardware capture events copy the counter into the capture registers. The capture mode decides which events load which register:
- rising edges on two separate pins,
- the rising and falling edges of a single pin, or
- the rising and falling edges of the timer's own match output.

Software can also take a snapshot. Writing a zero into one bit of the mode register loads capture register 0.

Top module: `capture_timer`

Register map (address on `busAddr`; 16-bit data):
- 0 run: bit 0 is the run enable. All other bits read 0.
- 1 mode: bits [1:0] tick source, bit 2 clear-on-match enable, bits [4:3] capture mode, bit 5 software snapshot bit. Bits [15:6] read 0.
- 2 match value (read/write).
- 3 counter (read only).
- 4 capture 0 (read only).
- 5 capture 1 (read only).
- 6 and 7 read 0.

## Requirements
- R1: After reset:
  - the run bit, the counter, both capture registers, the match value and the match output are all 0;
  - the mode register reads 0x0020.
- R2: The counter advances by one only when the run bit is 1 and the selected tick source fires. The tick source is mode bits [1:0]:
  - 00: synchronised rising edge of pin 0;
  - 01: tick input `tickDiv1`;
  - 10: tick input `tickDiv4`;
  - 11: tick input `tickDiv16`.
- R3: On a tick where the counter equals the match value:
  - with mode bit 2 set, the counter becomes 0;
  - otherwise the counter goes up by one and wraps from 0xFFFF to 0.
- R4: The match output flips on exactly those ticks that find the counter equal to the match value. At no other time does it change.
- R5: With capture mode (mode bits [4:3]) 00, no pin or match-output edge changes either capture register.
- R6: With capture mode 01:
  - a rising edge of pin 0 loads capture 0 with the counter;
  - a rising edge of pin 1 loads capture 1 with the counter.
- R7: With capture mode 10:
  - a rising edge of pin 0 loads capture 0;
  - a falling edge of pin 0 loads capture 1.
- R8: With capture mode 11:
  - a rising edge of the match output loads capture 0;
  - a falling edge of the match output loads capture 1.
- R9: A mode write with bit 5 = 0 loads capture 0 with the counter value of the write cycle. A mode write with bit 5 = 1 takes no snapshot. Bit 5 always reads 1.
- R10: Mode bits [15:6] read 0 whatever value was written to them.
- R11: Pins pass through a two-flop synchroniser. Consider a pin change applied between clock edges. The capture it causes holds the counter value present after the second following rising clock edge, and the capture register shows that value after the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 3 | Register address |
| busWdata | input | 16 | Write data |
| rdData | output | 16 | Read data for `busAddr` (combinational) |
| pinIn | input | 2 | Asynchronous capture/count pins (bit 0 = pin 0) |
| tickDiv1 | input | 1 | Undivided tick pulse |
| tickDiv4 | input | 1 | Divide-by-4 tick pulse |
| tickDiv16 | input | 1 | Divide-by-16 tick pulse |
| matchOut | output | 1 | Match output level |

## Verification
The bench builds the block with its defaults: a 16-bit counter and two synchroniser stages. With a 16-bit counter, a full pass from 0 to 0xFFFF and back to 0 takes about 65,536 clock cycles when the undivided tick is held high. That makes the wrap boundary reachable inside the run. The small match values used in the clear tests make match-output toggling frequent enough to feed capture mode 11 many times.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_RUN   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_MODE  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_MATCH = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_COUNT = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_CAP0  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_CAP1  = 3'd5;

  localparam int BIT_CLR   = 2;
  localparam int BIT_CAPLO = 3;
  localparam int BIT_SNAP  = 5;
  localparam int MODE_BITS = 6;

  typedef enum logic [1:0] {
    SRC_PIN  = 2'b00,
    SRC_DIV1 = 2'b01,
    SRC_DIV4 = 2'b10,
    SRC_DIV16 = 2'b11
  } tickSrc_e;

  typedef enum logic [1:0] {
    CAP_OFF    = 2'b00,
    CAP_TWOPIN = 2'b01,
    CAP_BOTHED = 2'b10,
    CAP_MATCH  = 2'b11
  } capMode_e;

  typedef struct packed {
    logic tick;
    logic ld0;
    logic ld1;
  } ctStrobe_t;
endpackage

// File: rtl/ct_ctrl.sv
module ct_ctrl
  import ct_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  input  logic [1:0]        pinIn,
  input  logic              tickDiv1,
  input  logic              tickDiv4,
  input  logic              tickDiv16,
  input  logic              matchOut,
  input  logic [CNT_W-1:0]  countVal,
  input  logic [CNT_W-1:0]  cap0Val,
  input  logic [CNT_W-1:0]  cap1Val,
  output logic [CNT_W-1:0]  matchVal,
  output logic              clearEn,
  output ctStrobe_t         stb,
  output logic [CNT_W-1:0]  rdData
);
  localparam int PAD_W = CNT_W - MODE_BITS;

  logic [1:0] pinSync;
  logic [1:0] pinPrev;
  logic       matchPrev;
  logic       runEn;
  tickSrc_e   clkSel;
  capMode_e   capMode;

  for (genvar p = 0; p < 2; p++) begin : gSync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_STAGES-2:0], pinIn[p]};
    end
    assign pinSync[p] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinPrev   <= '0;
      matchPrev <= 1'b0;
    end else begin
      pinPrev   <= pinSync;
      matchPrev <= matchOut;
    end
  end

  logic rise0, fall0, rise1, mRise, mFall;
  assign rise0 = pinSync[0] & ~pinPrev[0];
  assign fall0 = ~pinSync[0] & pinPrev[0];
  assign rise1 = pinSync[1] & ~pinPrev[1];
  assign mRise = matchOut & ~matchPrev;
  assign mFall = ~matchOut & matchPrev;

  logic modeWr, snapReq;
  assign modeWr  = busWr && (busAddr == ADR_MODE);
  assign snapReq = modeWr && !busWdata[BIT_SNAP];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn    <= 1'b0;
      clkSel   <= SRC_PIN;
      clearEn  <= 1'b0;
      capMode  <= CAP_OFF;
      matchVal <= '0;
    end else if (busWr) begin
      if (busAddr == ADR_RUN) runEn <= busWdata[0];
      if (modeWr) begin
        clkSel  <= tickSrc_e'(busWdata[1:0]);
        clearEn <= busWdata[BIT_CLR];
        capMode <= capMode_e'(busWdata[BIT_CAPLO+1:BIT_CAPLO]);
      end
      if (busAddr == ADR_MATCH) matchVal <= busWdata;
    end
  end

  logic srcTick, hw0, hw1;
  always_comb begin
    unique case (clkSel)
      SRC_PIN:  srcTick = rise0;
      SRC_DIV1: srcTick = tickDiv1;
      SRC_DIV4: srcTick = tickDiv4;
      default:  srcTick = tickDiv16;
    endcase
    unique case (capMode)
      CAP_TWOPIN: begin hw0 = rise0; hw1 = rise1; end
      CAP_BOTHED: begin hw0 = rise0; hw1 = fall0; end
      CAP_MATCH:  begin hw0 = mRise; hw1 = mFall; end
      default:    begin hw0 = 1'b0;  hw1 = 1'b0;  end
    endcase
    stb.tick = runEn & srcTick;
    stb.ld0  = hw0 | snapReq;
    stb.ld1  = hw1;
  end

  always_comb begin
    unique case (busAddr)
      ADR_RUN:   rdData = {{(CNT_W-1){1'b0}}, runEn};
      ADR_MODE:  rdData = {{PAD_W{1'b0}}, 1'b1, capMode, clearEn, clkSel};
      ADR_MATCH: rdData = matchVal;
      ADR_COUNT: rdData = countVal;
      ADR_CAP0:  rdData = cap0Val;
      ADR_CAP1:  rdData = cap1Val;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/ct_datapath.sv
module ct_datapath
  import ct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctStrobe_t        stb,
  input  logic [CNT_W-1:0] matchVal,
  input  logic             clearEn,
  output logic [CNT_W-1:0] countVal,
  output logic [CNT_W-1:0] cap0Val,
  output logic [CNT_W-1:0] cap1Val,
  output logic             matchOut
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic atMatch;
  assign atMatch = (countVal == matchVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal <= '0;
      matchOut <= 1'b0;
    end else if (stb.tick) begin
      countVal <= (clearEn && atMatch) ? '0 : countVal + ONE;
      if (atMatch) matchOut <= ~matchOut;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cap0Val <= '0;
      cap1Val <= '0;
    end else begin
      if (stb.ld0) cap0Val <= countVal;
      if (stb.ld1) cap1Val <= countVal;
    end
  end
endmodule

// File: rtl/capture_timer.sv
module capture_timer
  import ct_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  rdData,
  input  logic [1:0]        pinIn,
  input  logic              tickDiv1,
  input  logic              tickDiv4,
  input  logic              tickDiv16,
  output logic              matchOut
);
  ctStrobe_t        stb;
  logic [CNT_W-1:0] countVal, cap0Val, cap1Val, matchVal;
  logic             clearEn;

  ct_ctrl #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .pinIn(pinIn), .tickDiv1(tickDiv1),
    .tickDiv4(tickDiv4), .tickDiv16(tickDiv16), .matchOut(matchOut),
    .countVal(countVal), .cap0Val(cap0Val), .cap1Val(cap1Val),
    .matchVal(matchVal), .clearEn(clearEn), .stb(stb), .rdData(rdData)
  );

  ct_datapath #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .matchVal(matchVal),
    .clearEn(clearEn), .countVal(countVal), .cap0Val(cap0Val),
    .cap1Val(cap1Val), .matchOut(matchOut)
  );
endmodule

// File: rtl/capture_timer_checker.sv
module capture_timer_checker
  import ct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input ctStrobe_t         stb,
  input logic [CNT_W-1:0]  countVal,
  input logic [CNT_W-1:0]  matchVal,
  input logic              clearEn,
  input logic [CNT_W-1:0]  cap0Val,
  input logic [CNT_W-1:0]  cap1Val,
  input logic              matchOut,
  input logic [ADDR_W-1:0] busAddr,
  input logic [CNT_W-1:0]  rdData
);
  // R2: without a tick the counter holds
  a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rstN)
    !stb.tick |=> $stable(countVal));

  // R3: clear on match when enabled
  a_r3_clear_on_match: assert property (@(posedge clk) disable iff (!rstN)
    (stb.tick && clearEn && countVal == matchVal) |=> countVal == '0);

  // R3: wrap at the top of the range
  a_r3_wrap_top: assert property (@(posedge clk) disable iff (!rstN)
    (stb.tick && countVal == '1) |=> countVal == '0);

  // R4: match output only changes after a matching tick
  a_r4_toggle_on_match: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(matchOut) |-> $past(stb.tick && countVal == matchVal));

  // R5, R9: capture 0 only changes on a load strobe, and then takes the count
  a_r9_cap0_load: assert property (@(posedge clk) disable iff (!rstN)
    stb.ld0 |=> cap0Val == $past(countVal));
  a_r5_cap0_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ld0 |=> $stable(cap0Val));

  // R6, R7, R8: capture 1 loads the count on its strobe
  a_r8_cap1_load: assert property (@(posedge clk) disable iff (!rstN)
    stb.ld1 |=> cap1Val == $past(countVal));

  // R10: high mode bits read 0, snapshot bit reads 1
  a_r10_mode_read: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADR_MODE) |-> (rdData[CNT_W-1:MODE_BITS] == '0 && rdData[BIT_SNAP]));
endmodule

bind capture_timer capture_timer_checker #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .stb(stb), .countVal(countVal),
  .matchVal(matchVal), .clearEn(clearEn), .cap0Val(cap0Val),
  .cap1Val(cap1Val), .matchOut(matchOut), .busAddr(busAddr),
  .rdData(rdData)
);

// File: tb/capture_timer_test.sv
`timescale 1ns/1ps
module capture_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [2:0]  busAddr = 3'd0;
  logic [15:0] busWdata = '0;
  logic [15:0] rdData;
  logic [1:0]  pinIn = 2'b00;
  logic        tickDiv1 = 1'b0;
  logic        tickDiv4 = 1'b0;
  logic        tickDiv16 = 1'b0;
  logic        matchOut;

  always #2 clk = ~clk;

  capture_timer uut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .rdData(rdData), .pinIn(pinIn),
    .tickDiv1(tickDiv1), .tickDiv4(tickDiv4), .tickDiv16(tickDiv16),
    .matchOut(matchOut)
  );

  int    vecCnt = 0;
  int    missCnt = 0;
  string curReq = "R1";
  bit    done = 1'b0;

  // behavioural reference state
  int mCount, mMatch, mCap0, mCap1, mRun, mSel, mClr, mCapMode;
  bit mOut, mOutPrev;
  int q0[$];
  int q1[$];

  task automatic modelReset();
    mCount = 0; mMatch = 0; mCap0 = 0; mCap1 = 0; mRun = 0;
    mSel = 0; mClr = 0; mCapMode = 0; mOut = 0; mOutPrev = 0;
    q0 = '{0, 0, 0};
    q1 = '{0, 0, 0};
  endtask

  function automatic int modelRead(int a);
    case (a)
      0: return mRun;
      1: return mSel | (mClr << 2) | (mCapMode << 3) | 32;
      2: return mMatch;
      3: return mCount;
      4: return mCap0;
      5: return mCap1;
      default: return 0;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    vecCnt++;
    if (act != exp) begin
      missCnt++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      bit r0, f0, r1, mr, mf, src, tk, l0, l1, snap;
      int oldCount;
      r0 = q0[1] && !q0[0];
      f0 = !q0[1] && q0[0];
      r1 = q1[1] && !q1[0];
      mr = mOut && !mOutPrev;
      mf = !mOut && mOutPrev;
      case (mSel)
        0: src = r0;
        1: src = tickDiv1;
        2: src = tickDiv4;
        default: src = tickDiv16;
      endcase
      tk = (mRun != 0) && src;
      case (mCapMode)
        1: begin l0 = r0; l1 = r1; end
        2: begin l0 = r0; l1 = f0; end
        3: begin l0 = mr; l1 = mf; end
        default: begin l0 = 0; l1 = 0; end
      endcase
      snap = busWr && busAddr == 3'd1 && !busWdata[5];
      oldCount = mCount;
      mOutPrev = mOut;
      if (tk) begin
        if (mCount == mMatch) mOut = !mOut;
        if (mClr != 0 && mCount == mMatch) mCount = 0;
        else mCount = (mCount + 1) % 65536;
      end
      if (l0 || snap) mCap0 = oldCount;
      if (l1) mCap1 = oldCount;
      if (busWr) begin
        case (busAddr)
          3'd0: mRun = busWdata[0];
          3'd1: begin
            mSel = busWdata[1:0];
            mClr = busWdata[2];
            mCapMode = busWdata[4:3];
          end
          3'd2: mMatch = busWdata;
          default: ;
        endcase
      end
      q0.push_back(pinIn[0]); void'(q0.pop_front());
      q1.push_back(pinIn[1]); void'(q1.pop_front());
    end
    #1;
    if (!done) begin
      check({curReq, " rdData"}, rdData, modelRead(busAddr));
      check({curReq, " matchOut"}, matchOut, mOut);
    end
  end

  // free-running divided ticks
  initial begin
    int n = 0;
    forever begin
      @(negedge clk);
      n++;
      tickDiv4  = (n % 4) == 0;
      tickDiv16 = (n % 16) == 0;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      busWr = 1'b0;
      busAddr = 3'((i % 6));
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    busWr = 1'b1; busAddr = 3'(a); busWdata = 16'(d);
    @(negedge clk);
    busWr = 1'b0;
  endtask

  function automatic int modeWord(int sel, int clr, int cm, int snapBit);
    return sel | (clr << 2) | (cm << 3) | (snapBit << 5);
  endfunction

  task automatic expectRead(int a, int exp, string req);
    @(negedge clk);
    busWr = 1'b0; busAddr = 3'(a);
    @(posedge clk); #1;
    check(req, rdData, exp);
  endtask

  task automatic wigglePins(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      busAddr = 3'(3 + (i % 3));
      if (i % 5 == 0) pinIn[0] = ~pinIn[0];
      if (i % 7 == 0) pinIn[1] = ~pinIn[1];
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    curReq = "R1";
    expectRead(1, 16'h0020, "R1 mode reset");
    expectRead(3, 0, "R1 count reset");
    idle(8);

    curReq = "R5";
    wr(2, 5);
    wr(1, modeWord(1, 1, 0, 1));
    wr(0, 1);
    tickDiv1 = 1'b1;
    wigglePins(40);
    expectRead(4, 0, "R5 cap0 untouched");
    expectRead(5, 0, "R5 cap1 untouched");

    curReq = "R3";
    idle(20);
    curReq = "R4";
    idle(20);

    curReq = "R6";
    tickDiv1 = 1'b0;
    wr(2, 16'h00FF);
    wr(1, modeWord(2, 0, 1, 1));
    wigglePins(80);

    curReq = "R7";
    wr(1, modeWord(3, 0, 2, 1));
    wigglePins(120);

    curReq = "R11";
    @(negedge clk); pinIn = 2'b00;
    idle(5);
    @(negedge clk); pinIn[0] = 1'b1;
    idle(6);

    curReq = "R8";
    wr(2, 7);
    wr(1, modeWord(1, 1, 3, 1));
    tickDiv1 = 1'b1;
    idle(60);

    curReq = "R9";
    wr(1, modeWord(1, 1, 0, 0));
    idle(3);
    wr(1, modeWord(1, 1, 0, 1));
    idle(5);
    wr(1, modeWord(1, 1, 0, 0));
    idle(3);

    curReq = "R10";
    wr(1, 16'hFFDF);
    expectRead(1, 16'h003F, "R10 mode high bits");
    wr(1, modeWord(0, 0, 0, 1));

    curReq = "R2";
    tickDiv1 = 1'b0;
    wigglePins(60);
    wr(1, modeWord(3, 0, 0, 1));
    idle(70);
    wr(0, 0);
    expectRead(3, mCount, "R2 hold before idle");
    idle(40);
    wr(0, 1);

    curReq = "R3";
    wr(2, 3);
    wr(1, modeWord(1, 0, 0, 1));
    tickDiv1 = 1'b1;
    idle(65600);
    tickDiv1 = 1'b0;
    idle(4);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      missCnt++;
      vecCnt++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
      $finish;
    end
  end
endmodule